// File: doc/BRIEF.md
# Disk DMA Read-Burst Opening Sequencer

This block is the host-side controller that opens a device-to-host DMA burst on a parallel disk interface and later closes it. While no burst is active, it holds the acknowledge line negated. Through a one-cycle register stage it also passes the chip-select and address values from the host's register-access path onto the pins.

When the device raises its request line, the sequencer acts on three lines in the same cycle. It raises STOP, drives the host-ready line to its negated level, and forces both chip-selects high and the three address bits low. It then waits a programmable number of clock cycles before it drives the acknowledge line low. The acknowledge stays low for the whole burst. A termination request releases the acknowledge first. The address and chip-select lines return to the register path one cycle later.

A device that withdraws its request before being acknowledged breaks the protocol. In that case the sequencer goes back to idle without acknowledging and raises a one-cycle violation pulse. The block has no data path; strobing, pausing and CRC belong to other blocks.

Top module: `dma_in_burst_opener`

## Requirements
- R1: While `rst_n` is low, `ack_n`=1, `stop`=0, `host_rdy_n`=0, `cs_n`=all ones, `da`=0 and `seq_violation`=0.
- R2: In idle, `ack_n` stays 1, `stop` and `host_rdy_n` are 0, and `cs_n`/`da` equal `reg_cs_n`/`reg_da` as sampled at the previous clock edge.
- R3: The clock edge that samples `dev_req`=1 in idle makes `stop`=1, `host_rdy_n`=1, `cs_n`=all ones and `da`=0, all together, while `ack_n` stays 1.
- R4: With `setup_cycles`=N sampled at that edge, `ack_n` falls exactly N+1 clock cycles after the R3 outputs appear, and the R3 levels are held throughout.
- R5: During the burst, `ack_n` stays 0 and the R3 levels are held whatever `dev_req` does, until `term_req` is sampled as 1.
- R6: The edge that samples `term_req`=1 in a burst raises `ack_n` while `cs_n`=all ones, `da`=0 and `stop`=1 are still held. On the next edge the block returns to the R2 idle levels.
- R7: If `dev_req` is sampled low before `ack_n` has fallen, the block returns to idle levels on that edge, `ack_n` never falls, and `seq_violation` is 1 for exactly one cycle.
- R8: `term_req` has no effect in idle or during the setup wait.
- R9: A change of `setup_cycles` after the opening edge does not alter the acknowledge time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_req | input | 1 | Device request line (DMA request from the drive) |
| term_req | input | 1 | Host-side request to end the active burst |
| setup_cycles | input | CNT_W | Setup wait, in clock cycles, before acknowledge |
| reg_cs_n | input | CS_W | Chip-select levels from the register-access path |
| reg_da | input | DA_W | Address levels from the register-access path |
| ack_n | output | 1 | DMA acknowledge, active low |
| stop | output | 1 | STOP line to the device |
| host_rdy_n | output | 1 | Host ready line, active low |
| cs_n | output | CS_W | Chip-select pins, active low |
| da | output | DA_W | Device address pins |
| seq_violation | output | 1 | One-cycle pulse: request withdrawn before acknowledge |

## Verification
Every setup count from 0 to 7 is used to open and close a full burst. This shows whether the acknowledge edge moves by exactly one cycle per count, and catches any off-by-one in the down-counter or its zero test. For small counts, the request is withdrawn at every cycle of the setup wait, including the last one, where withdrawal and the zero count coincide. This separates a correct abort, with its single violation pulse, from a late acknowledge or a missing pulse. Further runs try the termination request in idle and during setup, a changed setup count after the start, request toggling inside a burst, and new register-path values. They show that only the intended inputs act on the pins.

// File: rtl/dma_in_burst_pkg.sv
package dma_in_burst_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SETUP   = 2'd1,
    ST_BURST   = 2'd2,
    ST_RELEASE = 2'd3
  } seq_state_e;

endpackage

// File: rtl/dma_setup_timer.sv
module dma_setup_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             dec,
  input  logic [CNT_W-1:0] load_val,
  output logic             at_zero
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (load)    cnt_q <= load_val;
    else if (dec && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign at_zero = (cnt_q == '0);

  // R9: the count captured at the opening edge is the one that runs
  assert_load_captures_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt_q == $past(load_val));

  // R4: the count only ever moves down by one while waiting
  assert_step_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
  import dma_in_burst_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dev_req,
  input  logic       term_req,
  input  logic       tmr_zero,
  output logic       tmr_load,
  output logic       tmr_dec,
  output seq_state_e state_d,
  output logic       violation
);

  seq_state_e state_q;
  logic       viol_q;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_dec  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (dev_req) begin
          state_d  = ST_SETUP;
          tmr_load = 1'b1;
        end
      end
      ST_SETUP: begin
        if (!dev_req)      state_d = ST_IDLE;
        else if (tmr_zero) state_d = ST_BURST;
        else               tmr_dec = 1'b1;
      end
      ST_BURST: begin
        if (term_req) state_d = ST_RELEASE;
      end
      ST_RELEASE: state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      viol_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      viol_q  <= (state_q == ST_SETUP) && !dev_req;
    end
  end

  assign violation = viol_q;

  // R7: violation is a single-cycle pulse
  assert_viol_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    viol_q |=> !viol_q);

  // R7: a violation only ever follows the setup wait
  assert_viol_after_setup_R7: assert property (@(posedge clk) disable iff (!rst_n)
    viol_q |-> state_q == ST_IDLE);

  // R5: a burst is left only through the release state
  assert_burst_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BURST) |=> (state_q == ST_BURST || state_q == ST_RELEASE));

endmodule

// File: rtl/dma_pin_driver.sv
module dma_pin_driver
  import dma_in_burst_pkg::*;
#(
  parameter int CS_W = 2,
  parameter int DA_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  seq_state_e      state_d,
  input  logic [CS_W-1:0] reg_cs_n,
  input  logic [DA_W-1:0] reg_da,
  output logic            ack_n,
  output logic            stop,
  output logic            host_rdy_n,
  output logic [CS_W-1:0] cs_n,
  output logic [DA_W-1:0] da
);

  localparam logic [CS_W-1:0] CS_OFF = '1;
  localparam logic [DA_W-1:0] DA_OFF = '0;

  logic hold_addr, hold_ctl, ack_on;

  always_comb begin
    hold_addr = (state_d != ST_IDLE);
    hold_ctl  = (state_d != ST_IDLE);
    ack_on    = (state_d == ST_BURST);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_n      <= 1'b1;
      stop       <= 1'b0;
      host_rdy_n <= 1'b0;
      cs_n       <= CS_OFF;
      da         <= DA_OFF;
    end else begin
      ack_n      <= !ack_on;
      stop       <= hold_ctl;
      host_rdy_n <= hold_ctl;
      cs_n       <= hold_addr ? CS_OFF : reg_cs_n;
      da         <= hold_addr ? DA_OFF : reg_da;
    end
  end

  // R5: address lines stay negated for as long as acknowledge is low
  assert_addr_off_in_burst_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n |-> (cs_n == CS_OFF && da == DA_OFF && stop && host_rdy_n));

  // R6: when acknowledge rises the address lines are still negated
  assert_release_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_n) |-> (cs_n == CS_OFF && da == DA_OFF && stop));

endmodule

// File: rtl/dma_in_burst_opener.sv
module dma_in_burst_opener
  import dma_in_burst_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int CS_W  = 2,
  parameter int DA_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dev_req,
  input  logic             term_req,
  input  logic [CNT_W-1:0] setup_cycles,
  input  logic [CS_W-1:0]  reg_cs_n,
  input  logic [DA_W-1:0]  reg_da,
  output logic             ack_n,
  output logic             stop,
  output logic             host_rdy_n,
  output logic [CS_W-1:0]  cs_n,
  output logic [DA_W-1:0]  da,
  output logic             seq_violation
);

  seq_state_e state_d;
  logic       tmr_load, tmr_dec, tmr_zero;

  dma_setup_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .dec      (tmr_dec),
    .load_val (setup_cycles),
    .at_zero  (tmr_zero)
  );

  dma_seq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .dev_req   (dev_req),
    .term_req  (term_req),
    .tmr_zero  (tmr_zero),
    .tmr_load  (tmr_load),
    .tmr_dec   (tmr_dec),
    .state_d   (state_d),
    .violation (seq_violation)
  );

  dma_pin_driver #(.CS_W(CS_W), .DA_W(DA_W)) u_pins (
    .clk        (clk),
    .rst_n      (rst_n),
    .state_d    (state_d),
    .reg_cs_n   (reg_cs_n),
    .reg_da     (reg_da),
    .ack_n      (ack_n),
    .stop       (stop),
    .host_rdy_n (host_rdy_n),
    .cs_n       (cs_n),
    .da         (da)
  );

  // R4: the three pre-acknowledge actions were all in place the cycle before
  assert_setup_before_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_n) |-> ($past(stop) && $past(host_rdy_n) &&
                      $past(cs_n) == '1 && $past(da) == '0 && $past(ack_n)));

  // R7: a violation pulse never coincides with an acknowledge
  assert_viol_no_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    seq_violation |-> ack_n);

  // R3: stop and host-ready move together
  assert_prep_together_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stop == host_rdy_n);

endmodule

// File: tb/sim_dma_in_burst_opener.sv
`timescale 1ns/1ps
module sim_dma_in_burst_opener;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       dev_req, term_req;
  logic [7:0] setup_cycles;
  logic [1:0] reg_cs_n;
  logic [2:0] reg_da;
  logic       ack_n, stop, host_rdy_n, seq_violation;
  logic [1:0] cs_n;
  logic [2:0] da;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  dma_in_burst_opener u0 (
    .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .term_req(term_req),
    .setup_cycles(setup_cycles), .reg_cs_n(reg_cs_n), .reg_da(reg_da),
    .ack_n(ack_n), .stop(stop), .host_rdy_n(host_rdy_n),
    .cs_n(cs_n), .da(da), .seq_violation(seq_violation)
  );

  localparam logic [7:0] PREP  = 8'b1_1_1_11_000;
  localparam logic [7:0] BURST = 8'b0_1_1_11_000;

  function automatic logic [7:0] pins();
    return {ack_n, stop, host_rdy_n, cs_n, da};
  endfunction

  function automatic logic [7:0] idle_pins(input logic [1:0] c, input logic [2:0] a);
    return {1'b1, 1'b0, 1'b0, c, a};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // full open/close with setup N
  task automatic open_close(input int n, input bit wiggle_setup, input bit term_in_setup);
    setup_cycles = 8'(n);
    dev_req = 1'b1;
    for (int j = 1; j <= n + 1; j++) begin
      @(negedge clk);
      if (j == 1) check("R3", pins(), PREP);
      else        check("R4", pins(), PREP);
      if (wiggle_setup) setup_cycles = 8'(n + 5);      // R9
      term_req = term_in_setup;                         // R8
    end
    @(negedge clk);
    check("R4", pins(), BURST);
    term_req = 1'b0;
    dev_req = 1'b0;                                     // R5
    @(negedge clk);
    check("R5", pins(), BURST);
    dev_req = 1'b1;
    @(negedge clk);
    check("R5", pins(), BURST);
    dev_req = 1'b0;
    term_req = 1'b1;
    @(negedge clk);
    check("R6", pins(), PREP);
    term_req = 1'b0;
    @(negedge clk);
    check("R6", pins(), idle_pins(reg_cs_n, reg_da));
    @(negedge clk);
  endtask

  // open with setup N, withdraw request at setup cycle k
  task automatic abort_at(input int n, input int k);
    setup_cycles = 8'(n);
    dev_req = 1'b1;
    for (int j = 1; j <= k; j++) begin
      @(negedge clk);
      check("R3", pins(), PREP);
    end
    dev_req = 1'b0;
    @(negedge clk);
    check("R7", {7'd0, seq_violation}, 32'd1);
    check("R7", pins(), idle_pins(reg_cs_n, reg_da));
    @(negedge clk);
    check("R7", {7'd0, seq_violation}, 32'd0);
    check("R7", pins(), idle_pins(reg_cs_n, reg_da));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; dev_req = 1'b0; term_req = 1'b0;
    setup_cycles = 8'd0; reg_cs_n = 2'b10; reg_da = 3'b101;
    repeat (3) @(negedge clk);
    check("R1", pins(), PREP & 8'b0_0_0_11_000 | 8'b1_0_0_00_000);
    check("R1", {7'd0, seq_violation}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2", pins(), idle_pins(2'b10, 3'b101));
    reg_cs_n = 2'b01; reg_da = 3'b010;
    @(negedge clk);
    check("R2", pins(), idle_pins(2'b01, 3'b010));
    term_req = 1'b1;                                    // R8 in idle
    @(negedge clk);
    check("R8", pins(), idle_pins(2'b01, 3'b010));
    term_req = 1'b0;
    @(negedge clk);

    for (int n = 0; n < 8; n++) open_close(n, 1'b0, 1'b0);
    open_close(3, 1'b1, 1'b0);                          // R9
    open_close(0, 1'b1, 1'b0);                          // R9
    open_close(2, 1'b0, 1'b1);                          // R8
    for (int n = 0; n < 6; n++)
      for (int k = 1; k <= n + 1; k++) abort_at(n, k);

    reg_cs_n = 2'b11; reg_da = 3'b111;
    open_close(1, 1'b0, 1'b0);
    check("R2", pins(), idle_pins(2'b11, 3'b111));

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule